// File: doc/BRIEF.md
# Sync Word Correlator

This block watches a serial received bit stream and flags the moment the most recent bits form a programmed sync or ID word. One bit enters per cycle of a data-clock strobe. The block keeps the newest 24 bits in a window. After every received bit it compares the lowest N bits of that window with the lowest N bits of a programmed pattern, where N is 12, 16, 20 or 24. It counts the positions that differ. The match is accepted when that count is no greater than a programmed tolerance of 0 to 3 bits. This lets a link protected by forward error correction still find its word when a few bits are corrupted.

On an accepted match the block raises a single interrupt line. The line clears by itself once nine further data-clock strobes have passed. A host uses it to learn that a valid channel has been found, without scanning the bit stream itself. Detection runs all the time and needs no framing signal. It is enabled only by two of the eight demodulator mode codes.

Top module: `sync_word_correlator`

## Requirements
- R1: While `rst_n` is low, `match_irq` is 0. Reset also empties the bit window to all zeros, so a pattern of zeros with length 12 and tolerance 0 matches on the first received 0 bit.
- R2: `bit_in` is taken only in cycles where `bit_stb` is 1. Toggling `bit_in` while `bit_stb` is 0 neither changes `match_irq` nor enters the window.
- R3: The word is sent MSB first. The newest received bit is compared with `pattern[0]`, and the bit received k strobes earlier is compared with `pattern[k]`.
- R4: `len_sel` selects the compared length: 00 = 12, 01 = 16, 10 = 20, 11 = 24 bits. Pattern bits and window bits at or above that length have no effect.
- R5: A match is accepted when the number of differing compared bits is at most `tol_sel`, read as an unsigned value from 0 to 3.
- R6: A match can raise `match_irq` only when `demod_mode` is 3'b010 or 3'b011. Every other code blocks detection.
- R7: After a match, `match_irq` stays 1 until the ninth data-clock strobe that follows the match. It drops at that strobe's clock edge.
- R8: A new match while `match_irq` is already 1 restarts the count of nine strobes.
- R9: `match_irq` rises at the rising clock edge that immediately follows the edge at which the completing bit was taken. It can change state only within two clock edges of a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_stb | input | 1 | Data-clock strobe; one received bit per high cycle |
| bit_in | input | 1 | Received serial data bit |
| pattern | input | 24 | Programmed sync/ID word, right-aligned |
| len_sel | input | 2 | Word length select (12/16/20/24 bits) |
| tol_sel | input | 2 | Accepted number of bit errors (0 to 3) |
| demod_mode | input | 3 | Demodulator mode; 010 or 011 enables detection |
| match_irq | output | 1 | Interrupt pulse on an accepted match |

## Verification
A bit is captured at the rising edge of its strobe. It is compared in the next cycle, and the interrupt register takes the result at the edge after that. The result is therefore due exactly one clock edge after the strobe edge.

The bench drives each bit on a falling edge and holds the strobe for one cycle. It then waits through the following rising edge and samples `match_irq` on the next falling edge. The latency test also samples at the falling edge between the two rising edges, to confirm the output is not yet set there.

The pulse-length checks count strobes rather than clocks. The ninth strobe after a match is the one whose edge must clear the output. A reference window kept in the bench predicts the expected level after every bit.

// File: rtl/swc_pkg.sv
package swc_pkg;
  // Widest word the correlator can hold
  localparam int unsigned SW_MAX     = 24;
  // Shortest selectable length and increment per select code
  localparam int unsigned SW_BASE    = 12;
  localparam int unsigned SW_STEP    = 4;
  // Strobes the interrupt stays high after a match
  localparam int unsigned IRQ_STROBES = 9;

  localparam int unsigned NW = $clog2(SW_MAX + 1);

  typedef logic [2:0] demod_t;
  localparam demod_t DEMOD_SYNC_A = 3'b010;
  localparam demod_t DEMOD_SYNC_B = 3'b011;

  function automatic logic [NW-1:0] word_len(input logic [1:0] sel);
    return NW'(SW_BASE + SW_STEP * int'(sel));
  endfunction
endpackage

// File: rtl/swc_shift_reg.sv
module swc_shift_reg #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic         din,
  output logic [W-1:0] win,
  output logic         fresh
);
  logic [W-1:0] win_q, win_d;
  logic         fresh_q, fresh_d;

  always_comb begin
    win_d   = win_q;
    fresh_d = stb;
    if (stb) begin
      win_d = {win_q[W-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      win_q   <= win_d;
      fresh_q <= fresh_d;
    end
  end

  assign win   = win_q;
  assign fresh = fresh_q;
endmodule

// File: rtl/swc_mismatch.sv
module swc_mismatch
  import swc_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] win,
  input  logic [W-1:0] pattern,
  input  logic [1:0]   len_sel,
  input  logic [1:0]   tol_sel,
  output logic         close_enough
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] nbits;
  logic [W-1:0]  mask;
  logic [W-1:0]  diff;
  logic [CW-1:0] errs;

  assign nbits = CW'(word_len(len_sel));

  // One mask bit per window position: compared when below the length
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (CW'(i) < nbits);
  end

  assign diff = (win ^ pattern) & mask;

  always_comb begin
    errs = '0;
    for (int i = 0; i < W; i++) begin
      errs = errs + CW'(diff[i]);
    end
  end

  assign close_enough = (errs <= CW'(tol_sel));
endmodule

// File: rtl/swc_pulse_timer.sv
module swc_pulse_timer #(
  parameter int unsigned LEN = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic hit,
  output logic irq
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          irq_q, irq_d;

  always_comb begin
    cnt_d = cnt_q;
    irq_d = irq_q;
    if (hit) begin
      irq_d = 1'b1;
      cnt_d = CW'(LEN);
    end else if (irq_q && stb) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        irq_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/sync_word_correlator.sv
module sync_word_correlator
  import swc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic [SW_MAX-1:0] pattern,
  input  logic [1:0]        len_sel,
  input  logic [1:0]        tol_sel,
  input  logic [2:0]        demod_mode,
  output logic              match_irq
);
  logic [SW_MAX-1:0] win;
  logic              fresh;
  logic              close_enough;
  logic              det_en;
  logic              hit;

  swc_shift_reg #(.W(SW_MAX)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (bit_stb),
    .din   (bit_in),
    .win   (win),
    .fresh (fresh)
  );

  swc_mismatch #(.W(SW_MAX)) u_cmp (
    .win          (win),
    .pattern      (pattern),
    .len_sel      (len_sel),
    .tol_sel      (tol_sel),
    .close_enough (close_enough)
  );

  assign det_en = (demod_mode == DEMOD_SYNC_A) || (demod_mode == DEMOD_SYNC_B);
  // One evaluation per received bit, in the cycle after it is captured
  assign hit    = fresh && det_en && close_enough;

  swc_pulse_timer #(.LEN(IRQ_STROBES)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (bit_stb),
    .hit   (hit),
    .irq   (match_irq)
  );
endmodule

// File: rtl/swc_checker.sv
module swc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_stb,
  input logic [2:0] demod_mode,
  input logic       match_irq
);
  // R7: the pulse only ends at a strobe edge
  a_r7_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(match_irq) |-> $past(bit_stb));

  // R9: a rise comes one edge after a strobe edge
  a_r9_rise_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_irq) |-> $past(bit_stb, 2));

  // R6: a rise needs an enabling mode code
  a_r6_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_irq) |-> ($past(demod_mode) == 3'b010 || $past(demod_mode) == 3'b011));

  // R2: without a recent strobe the output holds
  a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bit_stb) && !$past(bit_stb, 2)) |-> $stable(match_irq));
endmodule

bind sync_word_correlator swc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_stb    (bit_stb),
  .demod_mode (demod_mode),
  .match_irq  (match_irq)
);

// File: tb/tb_sync_word_correlator.sv
module tb_sync_word_correlator;
  logic        clk;
  logic        rst_n;
  logic        bit_stb;
  logic        bit_in;
  logic [23:0] pattern;
  logic [1:0]  len_sel;
  logic [1:0]  tol_sel;
  logic [2:0]  demod_mode;
  logic        match_irq;

  int total = 0;
  int bad   = 0;

  // reference state
  logic [23:0] m_hist;
  logic        m_irq;
  int          m_cnt;

  sync_word_correlator dut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
    .pattern(pattern), .len_sel(len_sel), .tol_sel(tol_sel),
    .demod_mode(demod_mode), .match_irq(match_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: match_irq=%0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic int nlen(input logic [1:0] s);
    return 12 + 4 * int'(s);
  endfunction

  function automatic int m_errs();
    int e = 0;
    for (int i = 0; i < nlen(len_sel); i++)
      if (m_hist[i] != pattern[i]) e++;
    return e;
  endfunction

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; bit_stb = 1'b0; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    check(tag, match_irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    m_hist = '0; m_irq = 1'b0; m_cnt = 0;
  endtask

  // drive one bit, update the reference, compare after the result edge
  task automatic send_bit(input logic b, input string tag);
    bit_stb = 1'b1; bit_in = b;
    @(negedge clk);
    bit_stb = 1'b0; bit_in = ~b;
    @(negedge clk);
    m_hist = {m_hist[22:0], b};
    if (m_irq) begin
      m_cnt--;
      if (m_cnt == 0) m_irq = 1'b0;
    end
    if ((demod_mode == 3'b010 || demod_mode == 3'b011) && m_errs() <= int'(tol_sel)) begin
      m_irq = 1'b1; m_cnt = 9;
    end
    check(tag, match_irq, m_irq);
  endtask

  task automatic send_word(input logic [23:0] w, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i], tag);
  endtask

  task automatic t_reset();
    pattern = '0; len_sel = 2'b00; tol_sel = 2'b00; demod_mode = 3'b010;
    do_reset("R1 reset low");
    send_bit(1'b0, "R1 cleared window");
    check("R1 zero word hit", match_irq, 1'b1);
  endtask

  task automatic t_no_strobe();
    pattern = 24'h000001; len_sel = 2'b00; tol_sel = 2'b00; demod_mode = 3'b010;
    do_reset("R2 reset");
    for (int i = 0; i < 20; i++) begin
      bit_in = i[0];
      @(negedge clk);
      check("R2 no strobe", match_irq, 1'b0);
    end
    send_bit(1'b1, "R2 window untouched");
    check("R2 hit after one strobe", match_irq, 1'b1);
  endtask

  task automatic t_order();
    pattern = 24'hA5C39E; len_sel = 2'b11; tol_sel = 2'b00; demod_mode = 3'b011;
    do_reset("R3 reset");
    send_word(24'h79C3A5, 24, "R3 reversed order");
    check("R3 LSB first rejected", match_irq, 1'b0);
    do_reset("R3 reset");
    send_word(pattern, 24, "R3 MSB first");
    check("R3 MSB first hit", match_irq, 1'b1);
  endtask

  task automatic t_len();
    for (int s = 0; s < 4; s++) begin
      len_sel = 2'(s); tol_sel = 2'b00; demod_mode = 3'b010;
      pattern = 24'h6B_2D_59;
      do_reset("R4 reset");
      // upper window bits filled with the complement of the pattern
      send_word(~pattern, 24, "R4 garbage");
      send_word(pattern, nlen(len_sel), "R4 word");
      check("R4 length hit", match_irq, 1'b1);
    end
  endtask

  task automatic t_tol();
    logic [23:0] w;
    pattern = 24'h00B38D; len_sel = 2'b01; demod_mode = 3'b010;
    for (int t = 0; t < 4; t++) begin
      for (int f = 0; f < 4; f++) begin
        tol_sel = 2'(t);
        do_reset("R5 reset");
        w = pattern;
        for (int k = 0; k < f; k++) w[15 - 3 * k] = ~w[15 - 3 * k];
        send_word(w, 16, "R5 bits");
        check("R5 tolerance", match_irq, (f <= t));
      end
    end
  endtask

  task automatic t_mode();
    pattern = 24'h000C5A; len_sel = 2'b00; tol_sel = 2'b00;
    for (int m = 0; m < 8; m++) begin
      demod_mode = 3'(m);
      do_reset("R6 reset");
      send_word(pattern, 12, "R6 bits");
      check("R6 mode gate", match_irq, (m == 2 || m == 3));
    end
  endtask

  task automatic t_width();
    pattern = 24'h000F00; len_sel = 2'b00; tol_sel = 2'b00; demod_mode = 3'b010;
    do_reset("R7 reset");
    send_word(pattern, 12, "R7 word");
    check("R7 set", match_irq, 1'b1);
    for (int i = 1; i <= 9; i++) begin
      send_bit(1'b0, "R7 countdown");
      check("R7 pulse width", match_irq, (i < 9));
    end
  endtask

  task automatic t_restart();
    pattern = '0; len_sel = 2'b00; tol_sel = 2'b00; demod_mode = 3'b011;
    do_reset("R8 reset");
    for (int i = 0; i < 16; i++) send_bit(1'b0, "R8 repeated hits");
    check("R8 held past nine", match_irq, 1'b1);
    for (int i = 1; i <= 9; i++) begin
      send_bit(1'b1, "R8 after last hit");
      check("R8 restart count", match_irq, (i < 9));
    end
  endtask

  task automatic t_latency();
    pattern = 24'h000ABC; len_sel = 2'b00; tol_sel = 2'b00; demod_mode = 3'b010;
    do_reset("R9 reset");
    send_word(24'h000ABC >> 1, 11, "R9 prefix");
    bit_stb = 1'b1; bit_in = 1'b0;
    @(negedge clk);
    bit_stb = 1'b0;
    check("R9 not before edge", match_irq, 1'b0);
    @(negedge clk);
    check("R9 one edge later", match_irq, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_stb = 1'b0; bit_in = 1'b0;
    pattern = '0; len_sel = '0; tol_sel = '0; demod_mode = '0;
    m_hist = '0; m_irq = 1'b0; m_cnt = 0;
    t_reset();
    t_no_strobe();
    t_order();
    t_len();
    t_tol();
    t_mode();
    t_width();
    t_restart();
    t_latency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule